// File: doc/BRIEF.md
# Multi-lane serial converter readout controller

This block is the host side of a readout link to a six-channel sampling converter. A read starts when the converter's conversion-busy line falls. The controller then pulls chip select low and generates serial clocks from the system clock. It shifts one bit per serial clock into each of three data-in lanes in parallel. When the frame is complete, the bits collected on each lane are sorted into six channel results, V1 to V6, and handed to the consumer.

The number of lanes in use (one, two or three) is a configuration input. It sets the frame length (96, 48 or 32 serial clocks) and decides which channel travels on which lane. A second input chooses between one continuous chip-select window and shorter windows of 16 or 32 clocks, with chip select raised between windows. A third input gives the result width (16, 14 or 12 bits); narrower results have their unused upper bits cleared. All three settings are captured when a read starts.

The result leaves the block on a valid/ready interface. `res_valid` stays high and `res_data` stays unchanged until the consumer raises `res_ready`. No new read starts while a result is waiting. A busy fall that arrives during that time is remembered and starts a read once the result has been taken.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset, `adc_cs_n` is 1, `adc_sclk` is 1 and `res_valid` is 0.
- R2: A read starts only after a 1-to-0 transition of `busy`. While `busy` is held steady, high or low, `adc_cs_n` stays high and no serial clock is produced.
- R3: `adc_sclk` idles high and falls only while `adc_cs_n` is low. Each half period lasts HALF_DIV system clocks. Every falling edge captures one bit per lane, and the first falling edge after chip select falls captures the bit presented when chip select fell.
- R4: `lane_mode` 2'd3 selects three lanes (32 serial clocks per frame), 2'd2 selects two lanes (48 clocks), and any other value selects one lane (96 clocks).
- R5: With three lanes, each lane carries two results, MSB first: lane 0 carries V1 then V2, lane 1 carries V3 then V4, and lane 2 carries V5 then V6.
- R6: With two lanes, lane 0 carries V1, V2, V5 in that order and lane 1 carries V3, V4, V6 in that order.
- R7: With one lane, lane 0 carries V1 through V6 in order.
- R8: `frame_mode` 2'd1 raises chip select after every 32 clocks and 2'd2 after every 16 clocks. 2'd0 and 2'd3 keep chip select low for the whole frame. The number of chip-select falls per read is the frame length divided by the window length, rounded up.
- R9: `res_bits` 2'd0 keeps all 16 bits, 2'd1 keeps the low 14 bits and 2'd2 or 2'd3 keeps the low 12 bits. The bits not kept read as zero.
- R10: `res_data` packs V(k+1) into bits [16k+15:16k]. `res_valid` rises after a frame and stays high with `res_data` unchanged until a cycle with `res_ready` high. No read starts while it is high, and a `busy` fall seen meanwhile starts a read after acceptance.
- R11: Lanes not used by the selected lane mode have no effect on `res_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | Converter busy; a falling edge requests a read |
| lane_mode | input | 2 | Number of data lanes in use |
| frame_mode | input | 2 | Chip-select window length |
| res_bits | input | 2 | Result width selection |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_sdata | input | 3 | Serial data lanes 0 to 2 |
| res_valid | output | 1 | Result set available |
| res_ready | input | 1 | Consumer accepts the result set |
| res_data | output | 96 | Six results, V1 in the low bits |

## Verification
The assertions check, on every cycle, that the serial clock falls only inside a chip-select window and that the bit counter never passes the frame length. They also check that an idle controller with no pending request keeps chip select high, and that a waiting result stays valid and stable with no frame running. Only the bench's scenarios can show that bits reach the correct channel for each lane count, that width masking and window splitting are right, that junk on unused lanes is ignored, and that a busy fall during back-pressure is honoured later.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int unsigned NCH   = 6;
  localparam int unsigned NLANE = 3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LEAD,
    S_LO,
    S_HI,
    S_GAP
  } seq_st_t;
endpackage

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned WORD     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       hold,
  input  logic [1:0] lane_mode,
  input  logic [1:0] frame_mode,
  input  logic [1:0] res_bits,
  output logic       cs_n,
  output logic       sclk,
  output logic       cap,
  output logic       frame_end,
  output logic [1:0] lm_q,
  output logic [1:0] rb_q
);
  localparam int unsigned FRW = $clog2(NCH * WORD + 1);
  localparam int unsigned TW  = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);

  seq_st_t        st;
  logic           busy_q, pend;
  logic [TW-1:0]  tmr;
  logic           tmr_done;
  logic [1:0]     fm_q;
  logic [FRW-1:0] bit_cnt, seg_cnt, total, seg_len;

  assign tmr_done = (tmr == TW'(HALF_DIV - 1));

  always_comb begin
    unique case (lm_q)
      2'd3:    total = FRW'(2 * WORD);
      2'd2:    total = FRW'(3 * WORD);
      default: total = FRW'(6 * WORD);
    endcase
    unique case (fm_q)
      2'd1:    seg_len = FRW'(2 * WORD);
      2'd2:    seg_len = FRW'(WORD);
      default: seg_len = total;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      busy_q    <= 1'b0;
      pend      <= 1'b0;
      tmr       <= '0;
      cs_n      <= 1'b1;
      sclk      <= 1'b1;
      cap       <= 1'b0;
      frame_end <= 1'b0;
      lm_q      <= 2'd0;
      fm_q      <= 2'd0;
      rb_q      <= 2'd0;
      bit_cnt   <= '0;
      seg_cnt   <= '0;
    end else begin
      busy_q    <= busy;
      cap       <= 1'b0;
      frame_end <= 1'b0;
      tmr       <= tmr_done ? '0 : tmr + 1'b1;
      unique case (st)
        S_IDLE: begin
          tmr <= '0;
          if (pend && !hold) begin
            pend    <= 1'b0;
            lm_q    <= lane_mode;
            fm_q    <= frame_mode;
            rb_q    <= res_bits;
            cs_n    <= 1'b0;
            bit_cnt <= '0;
            seg_cnt <= '0;
            st      <= S_LEAD;
          end
        end
        S_LEAD: if (tmr_done) begin
          sclk    <= 1'b0;
          cap     <= 1'b1;
          bit_cnt <= bit_cnt + 1'b1;
          seg_cnt <= seg_cnt + 1'b1;
          st      <= S_LO;
        end
        S_LO: if (tmr_done) begin
          sclk <= 1'b1;
          st   <= S_HI;
        end
        S_HI: if (tmr_done) begin
          if (bit_cnt == total) begin
            cs_n      <= 1'b1;
            frame_end <= 1'b1;
            st        <= S_IDLE;
          end else if (seg_cnt == seg_len) begin
            cs_n    <= 1'b1;
            seg_cnt <= '0;
            st      <= S_GAP;
          end else begin
            sclk    <= 1'b0;
            cap     <= 1'b1;
            bit_cnt <= bit_cnt + 1'b1;
            seg_cnt <= seg_cnt + 1'b1;
            st      <= S_LO;
          end
        end
        S_GAP: if (tmr_done) begin
          cs_n <= 1'b0;
          st   <= S_LEAD;
        end
        default: st <= S_IDLE;
      endcase
      if (busy_q && !busy) pend <= 1'b1;
    end
  end

  // R3
  sclk_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk |-> !cs_n);

  // R4
  bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= total);

  // R2
  no_start_unrequested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) && !pend |=> cs_n);
endmodule

// File: rtl/adc_rd_lane.sv
module adc_rd_lane #(
  parameter int unsigned DEPTH = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic             din,
  output logic [DEPTH-1:0] sh
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sh <= '0;
    else if (cap) sh <= {sh[DEPTH-2:0], din};
  end
endmodule

// File: rtl/adc_rd_map.sv
module adc_rd_map
  import adc_rd_pkg::*;
#(
  parameter int unsigned WORD = 16
) (
  input  logic [NLANE-1:0][NCH*WORD-1:0] sh,
  input  logic [1:0]                     lm,
  input  logic [1:0]                     rb,
  output logic [NCH*WORD-1:0]            vout
);
  localparam int unsigned DW = NCH * WORD;

  logic [WORD-1:0] ch [NCH];
  logic [WORD-1:0] keep;

  function automatic logic [WORD-1:0] pick(input logic [DW-1:0] v,
                                           input int n, input int j);
    return v[(n - 1 - j) * WORD +: WORD];
  endfunction

  always_comb begin
    unique case (lm)
      2'd3: begin
        ch[0] = pick(sh[0], 2, 0);
        ch[1] = pick(sh[0], 2, 1);
        ch[2] = pick(sh[1], 2, 0);
        ch[3] = pick(sh[1], 2, 1);
        ch[4] = pick(sh[2], 2, 0);
        ch[5] = pick(sh[2], 2, 1);
      end
      2'd2: begin
        ch[0] = pick(sh[0], 3, 0);
        ch[1] = pick(sh[0], 3, 1);
        ch[4] = pick(sh[0], 3, 2);
        ch[2] = pick(sh[1], 3, 0);
        ch[3] = pick(sh[1], 3, 1);
        ch[5] = pick(sh[1], 3, 2);
      end
      default: begin
        for (int k = 0; k < NCH; k++) ch[k] = pick(sh[0], NCH, k);
      end
    endcase
    unique case (rb)
      2'd0:    keep = {WORD{1'b1}};
      2'd1:    keep = {WORD{1'b1}} >> 2;
      default: keep = {WORD{1'b1}} >> 4;
    endcase
  end

  for (genvar k = 0; k < NCH; k++) begin : g_pack
    assign vout[k*WORD +: WORD] = ch[k] & keep;
  end
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned WORD     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 busy,
  input  logic [1:0]           lane_mode,
  input  logic [1:0]           frame_mode,
  input  logic [1:0]           res_bits,
  output logic                 adc_cs_n,
  output logic                 adc_sclk,
  input  logic [NLANE-1:0]     adc_sdata,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic [NCH*WORD-1:0]  res_data
);
  localparam int unsigned DW = NCH * WORD;

  logic                     cap, frame_end;
  logic [1:0]               lm_q, rb_q;
  logic [NLANE-1:0][DW-1:0] lane_sh;
  logic [DW-1:0]            mapped;

  adc_rd_seq #(.HALF_DIV(HALF_DIV), .WORD(WORD)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .hold       (res_valid | frame_end),
    .lane_mode  (lane_mode),
    .frame_mode (frame_mode),
    .res_bits   (res_bits),
    .cs_n       (adc_cs_n),
    .sclk       (adc_sclk),
    .cap        (cap),
    .frame_end  (frame_end),
    .lm_q       (lm_q),
    .rb_q       (rb_q)
  );

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    adc_rd_lane #(.DEPTH(DW)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .cap   (cap),
      .din   (adc_sdata[l]),
      .sh    (lane_sh[l])
    );
  end

  adc_rd_map #(.WORD(WORD)) u_map (
    .sh   (lane_sh),
    .lm   (lm_q),
    .rb   (rb_q),
    .vout (mapped)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (frame_end) begin
      res_valid <= 1'b1;
      res_data  <= mapped;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data));

  // R10
  no_frame_while_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> adc_cs_n && adc_sclk);
endmodule

// File: tb/adc_rd_ctrl_bench.sv
module adc_rd_ctrl_bench;
  localparam int W = 16;
  localparam int DW = 6 * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          busy = 1'b0;
  logic [1:0]    lane_mode = 2'd3, frame_mode = 2'd0, res_bits = 2'd0;
  logic          adc_cs_n, adc_sclk;
  logic [2:0]    adc_sdata;
  logic          res_valid;
  logic          res_ready = 1'b0;
  logic [DW-1:0] res_data;

  int checks = 0, errors = 0;
  int nfall = 0, ncs = 0, bad_sclk = 0;
  int idx = 0;
  logic [DW-1:0] strm [3];
  logic [W-1:0]  vals [6];

  always #5 clk = ~clk;

  adc_rd_ctrl u_adc_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .busy(busy), .lane_mode(lane_mode),
    .frame_mode(frame_mode), .res_bits(res_bits), .adc_cs_n(adc_cs_n),
    .adc_sclk(adc_sclk), .adc_sdata(adc_sdata), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data)
  );

  // converter model: first bit on chip-select fall, next bit on sclk rise
  task automatic drive_bits();
    for (int l = 0; l < 3; l++)
      adc_sdata[l] = (idx < DW) ? strm[l][DW-1-idx] : 1'b0;
  endtask

  always @(negedge adc_cs_n) drive_bits();
  always @(posedge adc_sclk) if (adc_cs_n === 1'b0) begin idx++; drive_bits(); end

  always @(negedge adc_sclk) if (rst_n) begin
    nfall++;
    if (adc_cs_n !== 1'b0) bad_sclk++;
  end
  always @(negedge adc_cs_n) if (rst_n) ncs++;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int nlanes(input logic [1:0] lm);
    return (lm == 2'd3) ? 3 : (lm == 2'd2) ? 2 : 1;
  endfunction

  function automatic int exp_clks(input logic [1:0] lm);
    return 6 * W / nlanes(lm);
  endfunction

  function automatic int exp_cs(input logic [1:0] lm, input logic [1:0] fm);
    int t = exp_clks(lm);
    int s = (fm == 2'd1) ? 2 * W : (fm == 2'd2) ? W : t;
    return (t + s - 1) / s;
  endfunction

  // channel carried by lane l, slot j (-1 when none)
  function automatic int chan_of(input logic [1:0] lm, input int l, input int j);
    if (nlanes(lm) == 3) return l * 2 + j;
    if (nlanes(lm) == 2) begin
      if (l == 0) return (j == 2) ? 4 : j;
      if (l == 1) return (j == 2) ? 5 : j + 2;
      return -1;
    end
    return (l == 0) ? j : -1;
  endfunction

  function automatic logic [W-1:0] keep_mask(input logic [1:0] rb);
    return (rb == 2'd0) ? 16'hFFFF : (rb == 2'd1) ? 16'h3FFF : 16'h0FFF;
  endfunction

  logic [1:0] cur_lm, cur_fm, cur_rb;

  task automatic prep(input logic [1:0] lm, input logic [1:0] fm, input logic [1:0] rb);
    int n = 6 / nlanes(lm);
    cur_lm = lm; cur_fm = fm; cur_rb = rb;
    lane_mode = lm; frame_mode = fm; res_bits = rb;
    for (int k = 0; k < 6; k++) vals[k] = W'($urandom);
    for (int l = 0; l < 3; l++) begin
      strm[l] = {$urandom, $urandom, $urandom};  // junk for unused lanes (R11)
      if (chan_of(lm, l, 0) >= 0)
        for (int j = 0; j < n; j++)
          strm[l][DW-1-W*j -: W] = vals[chan_of(lm, l, j)];
    end
    idx = 0; nfall = 0; ncs = 0; bad_sclk = 0;
  endtask

  task automatic pulse_busy();
    @(negedge clk) busy = 1'b1;
    repeat (3) @(negedge clk);
    busy = 1'b0;
  endtask

  task automatic collect(input string tag);
    bit got = 0;
    string rq;
    for (int c = 0; c < 5000 && !got; c++) begin
      @(negedge clk);
      if (res_valid) got = 1;
    end
    chk(got, "R10", {tag, " result valid"}, longint'(got), 1);
    rq = (nlanes(cur_lm) == 3) ? "R5" : (nlanes(cur_lm) == 2) ? "R6" : "R7";
    for (int k = 0; k < 6; k++)
      chk(res_data[k*W +: W] == (vals[k] & keep_mask(cur_rb)),
          {rq, "/R9/R11"}, $sformatf("%s V%0d", tag, k + 1),
          longint'(res_data[k*W +: W]), longint'(vals[k] & keep_mask(cur_rb)));
    chk(nfall == exp_clks(cur_lm), "R4", {tag, " sclk count"}, nfall, exp_clks(cur_lm));
    chk(ncs == exp_cs(cur_lm, cur_fm), "R8", {tag, " cs windows"}, ncs, exp_cs(cur_lm, cur_fm));
    chk(bad_sclk == 0, "R3", {tag, " sclk outside window"}, bad_sclk, 0);
  endtask

  task automatic accept();
    @(negedge clk) res_ready = 1'b1;
    @(negedge clk) res_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] snap;
    void'($urandom(32'h1F2E3D4C));
    adc_sdata = '0;
    for (int l = 0; l < 3; l++) strm[l] = '0;
    repeat (3) @(negedge clk);
    // R1
    chk(adc_cs_n === 1'b1 && adc_sclk === 1'b1 && res_valid === 1'b0,
        "R1", "reset outputs", {adc_cs_n, adc_sclk, res_valid}, 3'b110);
    rst_n = 1'b1;
    // R2: no busy edge, then busy held high, no read
    repeat (40) @(negedge clk);
    chk(adc_cs_n === 1'b1 && nfall == 0, "R2", "idle with busy low", adc_cs_n, 1);
    busy = 1'b1;
    repeat (40) @(negedge clk);
    chk(adc_cs_n === 1'b1 && nfall == 0, "R2", "busy held high", adc_cs_n, 1);
    prep(2'd3, 2'd0, 2'd0);
    busy = 1'b0;
    collect("r2_first");
    accept();

    // directed sweep of lane and window modes
    for (int lm = 1; lm <= 3; lm++)
      for (int fm = 0; fm <= 3; fm++) begin
        prep(2'(lm), 2'(fm), 2'($urandom_range(0, 3)));
        pulse_busy();
        collect($sformatf("lm%0d_fm%0d", lm, fm));
        accept();
      end

    // lane mode 0 behaves as one lane, 14-bit width
    prep(2'd0, 2'd2, 2'd1);
    pulse_busy();
    collect("lm0_r9");
    accept();

    // R10: back-pressure with a busy fall while the result waits
    prep(2'd2, 2'd1, 2'd0);
    pulse_busy();
    collect("r10_first");
    snap = res_data;
    prep(2'd3, 2'd2, 2'd2);
    pulse_busy();
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (!(res_valid && res_data == snap && adc_cs_n)) begin
        chk(1'b0, "R10", "hold under back-pressure", res_data[W-1:0], snap[W-1:0]);
        break;
      end
    end
    chk(res_valid === 1'b1 && res_data == snap, "R10", "held result",
        res_data[W-1:0], snap[W-1:0]);
    accept();
    collect("r10_pending");
    accept();

    // random frames
    for (int t = 0; t < 8; t++) begin
      prep(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
      pulse_busy();
      collect($sformatf("rand%0d", t));
      repeat ($urandom_range(0, 5)) @(negedge clk);
      accept();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule